// File: doc/BRIEF.md
# Timer interrupt status flag register

This block is an 8-bit status register on a simple CPU bus. It records underflow events from two down-counting timers. Each timer delivers a one-cycle underflow pulse, and the block turns each pulse into a sticky flag. Each flag drives its own interrupt request line, which stays high for as long as the flag is set. The flag for the first timer also takes the underflow that occurs when the two timers are chained into one 16-bit counter; the chaining happens upstream, so this block sees it only as the same pulse.

Software clears a flag with a two-step handshake. It first reads the register and sees the flag at 1, then writes 0 to that bit. Each flag keeps a private "armed" bit that remembers the read. Any write, whatever its data, drops every armed bit, so each clear needs a new read. A flag that software never saw set cannot be cleared by accident. The low six bits are reserved: they always read as 1 and ignore writes. Read data comes combinationally from the current register value.

Top module: `tmr_irq_stat`

## Requirements
- R1: While reset is asserted at a clock edge, the register returns to 0x3F: both flags are 0, both interrupt outputs are low, and every armed bit is dropped.
- R2: An underflow pulse from timer 2 in a cycle makes bit 7 read 1 from the following cycle onward.
- R3: An underflow pulse from timer 1 in a cycle makes bit 6 read 1 from the following cycle onward.
- R4: A selected write with 0 in a flag bit clears that flag only when a selected read returned the flag as 1 earlier and no write came between that read and this write. A write of 0 with no such read leaves the flag at 1.
- R5: Writing 1 to a flag bit never sets it and never clears it.
- R6: Bits 5 to 0 always read 1, whatever is written to them.
- R7: Every selected write drops all armed bits, so a later write of 0 without a fresh read leaves the flag set.
- R8: When an underflow pulse arrives in the same cycle as a write that would clear its flag, the flag stays 1 and is left unarmed.
- R9: tmr2_irq equals bit 7 and tmr1_irq equals bit 6 of the register in every cycle.
- R10: A read that returns a flag as 0 does not arm it. A strobe with bus_sel low is neither a read nor a write.
- R11: Each flag arms on its own. After a read that saw only bit 7 set, a write of 0x00 clears bit 7 and leaves a bit 6 that was set later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select; qualifies both strobes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; 0 in bit 7 or 6 requests a clear |
| tmr1_uf | input | 1 | One-cycle underflow pulse of timer 1 (also the chained 16-bit case) |
| tmr2_uf | input | 1 | One-cycle underflow pulse of timer 2 |
| bus_rdata | output | 8 | Current register value: {flag2, flag1, 6'b111111} |
| tmr1_irq | output | 1 | Interrupt request of timer 1, equal to bit 6 |
| tmr2_irq | output | 1 | Interrupt request of timer 2, equal to bit 7 |

## Verification
Every effect has a latency of one cycle. An underflow, a clearing write or reset seen at a rising edge shows on bus_rdata and the interrupt outputs right after that edge. An armed bit set by a read matters only to the next write. The driver applies one bus or pulse operation per cycle on the falling edge. After the rising edge it queues the register value that the requirements give for that operation. The monitor takes that item from the queue on the next falling edge and compares bus_rdata and both interrupt lines, so each check lands exactly one register stage after its stimulus.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int unsigned TIS_DATA_W = 8;
  localparam int unsigned TIS_N_SRC  = 2;
  localparam int unsigned TIS_RSVD_W = TIS_DATA_W - TIS_N_SRC;

  typedef logic [TIS_N_SRC-1:0] tis_src_vec_t;
endpackage

// File: rtl/tis_flag_cell.sv
// One sticky flag with its read-then-clear arming bit.
module tis_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic set_pulse,
  output logic flag_q
);
  logic armed_q;
  logic clr_ok;

  assign clr_ok = wr_hit && armed_q && !wr_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // an underflow wins over a clear in the same cycle
      if (set_pulse)   flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      // any write disarms; only a read that sees 1 arms
      if (wr_hit)                armed_q <= 1'b0;
      else if (rd_hit && flag_q) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tis_rdata_pack.sv
// Forms the read word: flags on top, constant ones below.
module tis_rdata_pack #(
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_SRC-1:0]  flags,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned RSVD_W = DATA_W - N_SRC;
  assign word = {flags, {RSVD_W{1'b1}}};
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat
  import tis_pkg::*;
#(
  parameter int unsigned DATA_W = TIS_DATA_W,
  parameter int unsigned N_SRC  = TIS_N_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tmr1_uf,
  input  logic              tmr2_uf,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tmr1_irq,
  output logic              tmr2_irq
);
  localparam int unsigned FLAG_LSB = DATA_W - N_SRC;

  logic             rd_hit;
  logic             wr_hit;
  logic [N_SRC-1:0] uf_vec;
  logic [N_SRC-1:0] flag_vec;

  assign rd_hit = bus_sel && bus_rd;
  assign wr_hit = bus_sel && bus_wr;
  assign uf_vec = {tmr2_uf, tmr1_uf};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    tis_flag_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .rd_hit    (rd_hit),
      .wr_hit    (wr_hit),
      .wr_bit    (bus_wdata[FLAG_LSB+i]),
      .set_pulse (uf_vec[i]),
      .flag_q    (flag_vec[i])
    );
  end

  tis_rdata_pack #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_pack (
    .flags (flag_vec),
    .word  (bus_rdata)
  );

  assign tmr1_irq = flag_vec[0];
  assign tmr2_irq = flag_vec[N_SRC-1];
endmodule

// File: rtl/tis_checker.sv
module tis_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       wd7,
  input logic       wd6,
  input logic       tmr1_uf,
  input logic       tmr2_uf,
  input logic [7:0] bus_rdata,
  input logic       tmr1_irq,
  input logic       tmr2_irq
);
  p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == 8'h3F));

  p_uf2_sets_r2: assert property (@(posedge clk) disable iff (rst)
    tmr2_uf |=> bus_rdata[7]);

  p_uf1_sets_r3: assert property (@(posedge clk) disable iff (rst)
    tmr1_uf |=> bus_rdata[6]);

  p_clear_by_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(bus_rdata[7])) |-> $past(bus_sel && bus_wr && !wd7));

  p_clear_by_write6_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(bus_rdata[6])) |-> $past(bus_sel && bus_wr && !wd6));

  p_no_set_by_write_r5: assert property (@(posedge clk) disable iff (rst)
    (!bus_rdata[7] && !tmr2_uf) |=> !bus_rdata[7]);

  p_reserved_ones_r6: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[5:0] == 6'h3F);

  p_race_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && tmr1_uf) |=> bus_rdata[6]);

  p_irq_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    (tmr2_irq == bus_rdata[7]) && (tmr1_irq == bus_rdata[6]));
endmodule

bind tmr_irq_stat tis_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .wd7       (bus_wdata[7]),
  .wd6       (bus_wdata[6]),
  .tmr1_uf   (tmr1_uf),
  .tmr2_uf   (tmr2_uf),
  .bus_rdata (bus_rdata),
  .tmr1_irq  (tmr1_irq),
  .tmr2_irq  (tmr2_irq)
);

// File: tb/sim_tmr_irq_stat.sv
module sim_tmr_irq_stat;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       tmr1_uf = 1'b0, tmr2_uf = 1'b0;
  logic [7:0] bus_rdata;
  logic       tmr1_irq, tmr2_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  tmr_irq_stat u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .tmr1_uf(tmr1_uf), .tmr2_uf(tmr2_uf),
    .bus_rdata(bus_rdata), .tmr1_irq(tmr1_irq), .tmr2_irq(tmr2_irq)
  );

  // monitor: one queued result per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (bus_rdata !== it.exp || tmr2_irq !== it.exp[7] || tmr1_irq !== it.exp[6]) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq2=%b irq1=%b expected rdata=%h irq2=%b irq1=%b",
                 it.tag, bus_rdata, tmr2_irq, tmr1_irq, it.exp, it.exp[7], it.exp[6]);
      end
    end
  end

  // driver: one operation per cycle, queue the value due after the edge
  task automatic step(input logic r, input logic s, input logic rd, input logic wr,
                      input logic [7:0] wd, input logic u1, input logic u2,
                      input logic [7:0] exp, input string tag);
    @(negedge clk);
    rst = r; bus_sel = s; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    tmr1_uf = u1; tmr2_uf = u2;
    @(posedge clk);
    #1;
    sb_q.push_back('{exp: exp, tag: tag});
  endtask

  task automatic idle(input logic [7:0] exp, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, exp, tag);
  endtask
  task automatic rd_op(input logic [7:0] exp, input string tag);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, exp, tag);
  endtask
  task automatic wr_op(input logic [7:0] d, input logic [7:0] exp, input string tag);
    step(1'b0, 1'b1, 1'b0, 1'b1, d, 1'b0, 1'b0, exp, tag);
  endtask
  task automatic uf(input logic u1, input logic u2, input logic [7:0] exp, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, u1, u2, exp, tag);
  endtask

  initial begin
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h3F, "R1 reset value");
    idle(8'h3F, "R1 idle after reset");
    wr_op(8'h00, 8'h3F, "R6 reserved bits ignore write 0");
    uf(1'b0, 1'b1, 8'hBF, "R2 timer2 underflow sets bit7");
    wr_op(8'h00, 8'hBF, "R4 write 0 without read keeps flag");
    rd_op(8'hBF, "R4 read sees bit7");
    wr_op(8'h00, 8'h3F, "R4 read then write 0 clears bit7");
    uf(1'b1, 1'b0, 8'h7F, "R3 timer1 underflow sets bit6, R9 irq1");
    rd_op(8'h7F, "R9 irq1 holds");
    wr_op(8'hFF, 8'h7F, "R5 write 1 leaves flag");
    wr_op(8'h00, 8'h7F, "R7 previous write disarmed");
    rd_op(8'h7F, "R7 rearm read");
    wr_op(8'hBF, 8'h3F, "R4 write 0 to bit6 only clears");
    rd_op(8'h3F, "R10 read of zero flags");
    uf(1'b0, 1'b1, 8'hBF, "R2 set after empty read");
    wr_op(8'h00, 8'hBF, "R10 zero read did not arm");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hBF, "R10 unselected read");
    wr_op(8'h00, 8'hBF, "R10 unselected read did not arm");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hBF, "R10 unselected write");
    rd_op(8'hBF, "R4 read");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hBF, "R10 unselected write no clear");
    wr_op(8'h00, 8'h3F, "R10 arming kept over unselected write");
    uf(1'b1, 1'b0, 8'h7F, "R3 set again");
    rd_op(8'h7F, "R8 arm bit6");
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h7F, "R8 underflow beats clear");
    wr_op(8'h00, 8'h7F, "R8 flag left unarmed");
    rd_op(8'h7F, "R4 read");
    wr_op(8'h00, 8'h3F, "R4 clear bit6");
    uf(1'b0, 1'b1, 8'hBF, "R2 set bit7");
    rd_op(8'hBF, "R11 read arms bit7 only");
    uf(1'b1, 1'b0, 8'hFF, "R3 set bit6 after read");
    wr_op(8'h00, 8'h7F, "R11 only armed bit cleared");
    rd_op(8'h7F, "R11 read");
    wr_op(8'h00, 8'h3F, "R11 clear bit6");
    uf(1'b1, 1'b1, 8'hFF, "R2 R3 both underflow together");
    rd_op(8'hFF, "R9 both irqs high");
    wr_op(8'h40, 8'h7F, "R5 bit6 written 1 survives, bit7 cleared");
    rd_op(8'h7F, "R6 read");
    wr_op(8'hC0, 8'h7F, "R5 write 1 to armed bit6 keeps it");
    uf(1'b0, 1'b1, 8'hFF, "R2 set bit7");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h3F, "R1 reset clears flags");
    wr_op(8'h00, 8'h3F, "R1 reset idle");
    uf(1'b1, 1'b0, 8'h7F, "R3 set after reset");
    wr_op(8'h00, 8'h7F, "R1 reset dropped arming");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule